// File: doc/BRIEF.md
# Paper Feed Jam Detector with Latched Alarm

This block guards a paper feed path. Three contact sensors sit one after another along the path. Each sensor reads 1 while a sheet presses on it. In normal feeding a sheet never covers two neighbouring sensors at once, so seeing paper at two neighbours means the sheet has stalled or buckled. The block reports that condition live. It also latches an alarm that drives an LED and a buzzer, and it stops the feed motor until an operator presses a clear button.

The raw sensor and button lines are asynchronous and mechanical. Each line passes through a two-stage synchroniser and then a debounce filter before any decision is made. The motor side presents an enable and two direction lines to a half-H bridge. The direction lines are fixed at forward while the motor runs.

Top module: `paper_jam_guard`

## Requirements
- R1: The jam condition is (s0 and s1) or (s1 and s2) on the debounced sensor levels, where s0, s1 and s2 are bits 0, 1 and 2 of `sensorIn` in path order. Bits 0 and 2 active with bit 1 inactive is not a jam.
- R2: `jamLive` equals the debounced jam condition and drops as soon as that condition is gone, whatever the latch state.
- R3: Once set, `alarmLed` and `alarmBuzzer` stay at 1, and always equal each other, until a clear is accepted. Removing the paper alone does not turn them off.
- R4: A clear is accepted only while the debounced clear level is 1 and the debounced jam condition is 0. While the jam persists, set wins and the alarm stays on.
- R5: `motorEnable` is 1 exactly while the alarm is off. While it is 1, `motorDirFwd`=1 and `motorDirRev`=0. While it is 0, both direction outputs are 0.
- R6: Each input passes a two-flop synchroniser and a filter that accepts a new level only after it has been stable for STABLE_CYCLES (default 16) clocks. `jamLive` therefore changes STABLE_CYCLES+2 rising edges after the inputs change, and a pulse shorter than STABLE_CYCLES cycles has no effect.
- R7: The alarm sets and `motorEnable` drops on the first rising edge at which the debounced jam condition is 1, which is one edge after `jamLive` rises.
- R8: Synchronous active-high `rst` clears the alarm and the filters. After reset `jamLive`=0, the alarm is off and the motor is enabled and running forward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sensorIn | input | 3 | Raw contact sensors, bit 0 first along the path, 1 = paper present |
| clearBtn | input | 1 | Raw clear pushbutton, 1 = pressed |
| jamLive | output | 1 | Live debounced jam condition |
| alarmLed | output | 1 | Latched alarm lamp |
| alarmBuzzer | output | 1 | Latched alarm buzzer |
| motorEnable | output | 1 | Feed motor enable to the bridge |
| motorDirFwd | output | 1 | Bridge forward input |
| motorDirRev | output | 1 | Bridge reverse input |

## Verification
The table applies all eight sensor combinations from an idle path. This separates the two neighbour pairs and the all-on case, which must latch, from single sensors and the non-adjacent end pair, which must not. Directed cases then apply a jam and count edges to confirm the debounce latency and the one-edge step from the live flag to the latch. They also show that a short glitch is dropped, that removing the paper leaves the alarm set, that a clear pressed while paper is still jammed is overruled, and that reset releases a latched alarm.

// File: rtl/paper_jam_pkg.sv
package paper_jam_pkg;
  // Strobes from control to datapath for the alarm flip-flop
  typedef struct packed {
    logic setAlarm;
    logic clearAlarm;
  } latchCmd_t;
endpackage

// File: rtl/input_conditioner.sv
module input_conditioner #(
  parameter int STABLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic syncA, syncB;
  logic level;
  logic [CW-1:0] stableCnt;

  // two-stage synchroniser
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
    end
  end

  // accept a new level after STABLE_CYCLES consecutive differing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      level     <= 1'b0;
      stableCnt <= '0;
    end else if (syncB != level) begin
      if (stableCnt == LAST) begin
        level     <= syncB;
        stableCnt <= '0;
      end else begin
        stableCnt <= stableCnt + 1'b1;
      end
    end else begin
      stableCnt <= '0;
    end
  end

  assign cleanOut = level;
endmodule

// File: rtl/jam_datapath.sv
module jam_datapath
  import paper_jam_pkg::*;
#(
  parameter int NUM_SENSORS   = 3,
  parameter int STABLE_CYCLES = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_SENSORS-1:0] sensorIn,
  input  logic                   clearBtn,
  input  latchCmd_t              cmd,
  output logic                   jamNow,
  output logic                   clearLevel,
  output logic                   alarmQ
);
  localparam int PAIRS = NUM_SENSORS - 1;

  logic [NUM_SENSORS-1:0] sensorClean;
  logic [PAIRS-1:0]       pairHit;

  for (genvar i = 0; i < NUM_SENSORS; i++) begin : g_sens
    input_conditioner #(.STABLE_CYCLES(STABLE_CYCLES)) u_cond (
      .clk(clk), .rst(rst), .rawIn(sensorIn[i]), .cleanOut(sensorClean[i])
    );
  end

  input_conditioner #(.STABLE_CYCLES(STABLE_CYCLES)) u_clearCond (
    .clk(clk), .rst(rst), .rawIn(clearBtn), .cleanOut(clearLevel)
  );

  // only neighbouring sensors form a jam pair
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign pairHit[p] = sensorClean[p] & sensorClean[p+1];
  end

  assign jamNow = |pairHit;

  // alarm flip-flop: set over clear
  always_ff @(posedge clk) begin
    if (rst)                 alarmQ <= 1'b0;
    else if (cmd.setAlarm)   alarmQ <= 1'b1;
    else if (cmd.clearAlarm) alarmQ <= 1'b0;
  end
endmodule

// File: rtl/jam_control.sv
module jam_control
  import paper_jam_pkg::*;
(
  input  logic      jamNow,
  input  logic      clearLevel,
  input  logic      alarmQ,
  output latchCmd_t cmd,
  output logic      motorEnable,
  output logic      motorDirFwd,
  output logic      motorDirRev
);
  always_comb begin
    cmd.setAlarm   = jamNow;
    cmd.clearAlarm = clearLevel & ~jamNow;
  end

  always_comb begin
    motorEnable = ~alarmQ;
    motorDirFwd = ~alarmQ;
    motorDirRev = 1'b0;
  end
endmodule

// File: rtl/paper_jam_guard.sv
module paper_jam_guard
  import paper_jam_pkg::*;
#(
  parameter int NUM_SENSORS   = 3,
  parameter int STABLE_CYCLES = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_SENSORS-1:0] sensorIn,
  input  logic                   clearBtn,
  output logic                   jamLive,
  output logic                   alarmLed,
  output logic                   alarmBuzzer,
  output logic                   motorEnable,
  output logic                   motorDirFwd,
  output logic                   motorDirRev
);
  latchCmd_t cmd;
  logic jamNow, clearLevel, alarmQ;

  jam_datapath #(.NUM_SENSORS(NUM_SENSORS), .STABLE_CYCLES(STABLE_CYCLES)) u_dp (
    .clk(clk), .rst(rst), .sensorIn(sensorIn), .clearBtn(clearBtn),
    .cmd(cmd), .jamNow(jamNow), .clearLevel(clearLevel), .alarmQ(alarmQ)
  );

  jam_control u_ctl (
    .jamNow(jamNow), .clearLevel(clearLevel), .alarmQ(alarmQ), .cmd(cmd),
    .motorEnable(motorEnable), .motorDirFwd(motorDirFwd), .motorDirRev(motorDirRev)
  );

  assign jamLive     = jamNow;
  assign alarmLed    = alarmQ;
  assign alarmBuzzer = alarmQ;
endmodule

// File: rtl/paper_jam_guard_chk.sv
module paper_jam_guard_chk (
  input logic clk,
  input logic rst,
  input logic jamLive,
  input logic alarmLed,
  input logic alarmBuzzer,
  input logic motorEnable,
  input logic motorDirFwd,
  input logic motorDirRev,
  input logic clearLevel
);
  assert_lamps_agree_R3: assert property (@(posedge clk) disable iff (rst)
    alarmLed == alarmBuzzer);

  assert_release_needs_clear_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(alarmLed) |-> ($past(rst) || ($past(clearLevel) && !$past(jamLive))));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (alarmLed && jamLive) |=> alarmLed);

  assert_motor_halted_R5: assert property (@(posedge clk) disable iff (rst)
    alarmLed |-> (!motorEnable && !motorDirFwd && !motorDirRev));

  assert_motor_forward_R5: assert property (@(posedge clk) disable iff (rst)
    motorEnable |-> (motorDirFwd && !motorDirRev));

  assert_latch_next_edge_R7: assert property (@(posedge clk) disable iff (rst)
    jamLive |=> (alarmLed && !motorEnable));

  assert_reset_release_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!alarmLed && motorEnable && !jamLive));
endmodule

bind paper_jam_guard paper_jam_guard_chk u_chk (
  .clk(clk), .rst(rst), .jamLive(jamLive), .alarmLed(alarmLed),
  .alarmBuzzer(alarmBuzzer), .motorEnable(motorEnable),
  .motorDirFwd(motorDirFwd), .motorDirRev(motorDirRev), .clearLevel(clearLevel)
);

// File: tb/paper_jam_guard_test.sv
`timescale 1ns/1ps
module paper_jam_guard_test;
  localparam int DEB    = 16;
  localparam int SETTLE = DEB + 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] sensorIn = 3'b000;
  logic clearBtn = 1'b0;
  logic jamLive, alarmLed, alarmBuzzer, motorEnable, motorDirFwd, motorDirRev;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  paper_jam_guard #(.NUM_SENSORS(3), .STABLE_CYCLES(DEB)) uut (
    .clk(clk), .rst(rst), .sensorIn(sensorIn), .clearBtn(clearBtn),
    .jamLive(jamLive), .alarmLed(alarmLed), .alarmBuzzer(alarmBuzzer),
    .motorEnable(motorEnable), .motorDirFwd(motorDirFwd), .motorDirRev(motorDirRev)
  );

  // {pattern[2:0], expected jam}
  localparam logic [3:0] VECS [8] = '{
    4'b000_0, 4'b001_0, 4'b010_0, 4'b011_1,
    4'b100_0, 4'b101_0, 4'b110_1, 4'b111_1
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkAlarm(input string req, input logic exp);
    check(req, "alarmLed", alarmLed, exp);
    check(req, "alarmBuzzer", alarmBuzzer, exp);
    check(req, "motorEnable", motorEnable, !exp);
    check(req, "motorDirFwd", motorDirFwd, !exp);
    check(req, "motorDirRev", motorDirRev, 1'b0);
  endtask

  task automatic doClear();
    @(negedge clk); sensorIn = 3'b000;
    edges(SETTLE);
    @(negedge clk); clearBtn = 1'b1;
    edges(SETTLE);
    @(negedge clk); clearBtn = 1'b0;
    edges(SETTLE);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    edges(3);
    @(negedge clk); rst = 1'b0;
    #1;
    // R8: reset state
    check("R8", "jamLive", jamLive, 1'b0);
    checkAlarm("R8", 1'b0);

    // R1 R2 R3: every sensor combination from an idle path
    for (int v = 0; v < 8; v++) begin
      @(negedge clk); sensorIn = VECS[v][3:1];
      edges(SETTLE);
      check("R1", "jamLive", jamLive, VECS[v][0]);
      checkAlarm("R3", VECS[v][0]);
      doClear();
      check("R2", "jamLive after release", jamLive, 1'b0);
      checkAlarm("R3", 1'b0);
    end

    // R6 R7: latency count for a jam on the rear pair
    @(negedge clk); sensorIn = 3'b110;
    edges(DEB + 1);
    check("R6", "jamLive before debounce", jamLive, 1'b0);
    edges(1);
    check("R6", "jamLive at debounce", jamLive, 1'b1);
    check("R7", "alarmLed same edge as jamLive", alarmLed, 1'b0);
    edges(1);
    check("R7", "alarmLed next edge", alarmLed, 1'b1);
    check("R7", "motorEnable next edge", motorEnable, 1'b0);

    // R3: paper removed, alarm held, live flag gone
    @(negedge clk); sensorIn = 3'b000;
    edges(SETTLE);
    check("R2", "jamLive cleared paper", jamLive, 1'b0);
    checkAlarm("R3", 1'b1);

    // R4: clear pressed while jam still present
    @(negedge clk); sensorIn = 3'b011;
    edges(SETTLE);
    @(negedge clk); clearBtn = 1'b1;
    edges(SETTLE);
    checkAlarm("R4", 1'b1);
    @(negedge clk); sensorIn = 3'b000;
    edges(SETTLE);
    checkAlarm("R4", 1'b0);
    @(negedge clk); clearBtn = 1'b0;
    edges(SETTLE);

    // R6: short glitch on a jam pattern is dropped
    @(negedge clk); sensorIn = 3'b011;
    edges(DEB - 6);
    @(negedge clk); sensorIn = 3'b000;
    edges(SETTLE);
    check("R6", "jamLive after glitch", jamLive, 1'b0);
    checkAlarm("R6", 1'b0);

    // R8: reset releases a latched alarm
    @(negedge clk); sensorIn = 3'b111;
    edges(SETTLE);
    checkAlarm("R8", 1'b1);
    @(negedge clk); sensorIn = 3'b000; rst = 1'b1;
    edges(2);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R8", "jamLive after reset", jamLive, 1'b0);
    checkAlarm("R8", 1'b0);

    finishRun();
  end
endmodule